// File: doc/BRIEF.md
# Converter Command and Acquisition Sequencer

This block is the control core of a sampling converter. The host port decodes the configuration word and hands this block four things: the 3-bit command field, the 2-bit acquisition-length field and the sync-mode bit, plus a one-cycle pulse when a configuration write completes and a one-cycle pulse when a result read completes. From these the sequencer runs standby, wake-up, full calibration, auto-zero, abort and conversion. It drives an active-low ready line, an active-low standby line and the bidirectional sync pin, which is split here into an input, an output value and an output enable.

The sample window is timed in one of two ways. With the sync bit clear, an internal counter runs for 9, 15, 47 or 79 clocks, and the sync pin is an output that is high while converting. With the sync bit set, the pin is an input, and only its rising edge (seen through a two-stage synchronizer) closes the window and starts conversion. The conversion engine and the calibration engine are fixed-latency stubs inside the block. Conversion takes CONV_CYCLES clocks, full calibration takes CAL_CYCLES clocks and auto-zero takes CAL_CYCLES/8 clocks.

The states are SLEEP, WAKE, READY, FULLCAL, ZERO, ACQ_TIMED, ACQ_EXT and CONVERT. The transitions are as follows. An abort command goes from any state to READY. SLEEP goes to WAKE on any non-standby command. WAKE goes to FULLCAL, ZERO or READY when the wake timer ends. READY goes to SLEEP, FULLCAL or ZERO on the matching command. READY goes to ACQ_TIMED or ACQ_EXT on a read when the start command is loaded. In sync mode, READY goes straight to CONVERT on a sync rise when the start command is loaded. ACQ_TIMED goes to CONVERT when the counter ends, and ACQ_EXT goes to CONVERT on a sync rise. FULLCAL, ZERO and CONVERT each return to READY when their engine finishes.

Top module: `acq_sequencer`

## Requirements
- R1: After reset the block is in SLEEP: stdby_n_o is 0, rdy_n_o is 1 and sync_pin_o is 0.
- R2: In SLEEP, a write of any command other than 000 (standby) or 011 (abort) drives stdby_n_o high in the next cycle. rdy_n_o stays high for WAKE_CYCLES cycles. After that, command 001 runs a full calibration, command 010 runs an auto-zero, and any other command goes to ready (rdy_n_o low).
- R3: sync_pin_oe is 1 when ext_sync_i is 0 and 0 when ext_sync_i is 1. sync_pin_o is never high while ext_sync_i is 1.
- R4: With ext_sync_i at 0, acq_sel_i values 00, 01, 10 and 11 give acquisition windows of 9, 15, 47 and 79 cycles.
- R5: With ext_sync_i at 0, ready, and command 100 (start) loaded, a read pulse makes rdy_n_o high in the next cycle. The acquisition window follows. Then sync_pin_o is high for exactly CONV_CYCLES cycles, and rdy_n_o and sync_pin_o fall in the same cycle.
- R6: With ext_sync_i at 1, a read pulse in ready with start loaded makes rdy_n_o high, and the block waits for a sync rising edge however long that takes. acq_sel_i has no effect. A rise sampled on the third clock edge after the pin goes high starts CONV_CYCLES of conversion. Sync edges during a conversion are ignored.
- R7: With ext_sync_i at 1, ready, and start loaded, a sync rising edge alone makes rdy_n_o high and starts the conversion directly.
- R8: Command 001 (full calibration) in ready holds rdy_n_o high for CAL_CYCLES cycles. Command 010 (auto-zero) holds it high for CAL_CYCLES/8 cycles.
- R9: Command 011 (abort) in any state ends any activity. In the next cycle rdy_n_o is 0 and stdby_n_o is 1, with no wake delay when it comes from SLEEP.
- R10: While rdy_n_o is high and the block is not in SLEEP, any written command other than abort is ignored and is not loaded.
- R11: Command 000 written in ready makes stdby_n_o low and rdy_n_o high in the next cycle.
- R12: A read pulse in ready starts nothing unless the last loaded command is 100. Codes 101 to 111 load as no-operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| cfg_wr_i | input | 1 | One-cycle pulse: configuration write completed |
| cmd_i | input | 3 | Decoded command field |
| acq_sel_i | input | 2 | Acquisition-length field |
| ext_sync_i | input | 1 | 1 selects external sync timing, 0 selects internal timing |
| rd_done_i | input | 1 | One-cycle pulse: result read completed |
| sync_pin_i | input | 1 | Sync pin value seen at the pad |
| sync_pin_o | output | 1 | Sync pin drive value (high while converting) |
| sync_pin_oe | output | 1 | Sync pin output enable |
| rdy_n_o | output | 1 | Active-low ready |
| stdby_n_o | output | 1 | Active-low standby indicator |

## Verification
The hardest situations to reach are those that depend on the state the block is in when a command lands: a command written in the middle of an acquisition or conversion, or an abort during a long calibration. The stimulus reaches them by issuing writes at fixed delays after the read that starts a sequence, well inside the known window lengths. It then issues a later read to show that the ignored command did not replace the loaded start command. The external-sync wait is stretched past the longest internal window while acq_sel_i is 11, so that any leak of the internal counter shows up. A second sync pulse is placed inside the conversion to show that it is ignored.

// File: rtl/acq_seq_pkg.sv
`timescale 1ns/1ps
package acq_seq_pkg;

    localparam logic [2:0] OP_SLEEP   = 3'b000;
    localparam logic [2:0] OP_FULLCAL = 3'b001;
    localparam logic [2:0] OP_ZERO    = 3'b010;
    localparam logic [2:0] OP_ABORT   = 3'b011;
    localparam logic [2:0] OP_START   = 3'b100;

    typedef enum logic [2:0] {
        S_SLEEP,
        S_WAKE,
        S_READY,
        S_FULLCAL,
        S_ZERO,
        S_ACQ_TIMED,
        S_ACQ_EXT,
        S_CONVERT
    } seq_state_e;

    function automatic int acq_clocks(input logic [1:0] sel);
        case (sel)
            2'd0:    return 9;
            2'd1:    return 15;
            2'd2:    return 47;
            default: return 79;
        endcase
    endfunction

endpackage

// File: rtl/acq_seq_timer.sv
`timescale 1ns/1ps
module acq_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         abort,
    input  logic [W-1:0] len,
    output logic         done
);

    logic         busy_q;
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= len - W'(1);
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - W'(1);
            end
        end
    end

    assign done = busy_q && (cnt_q == '0);

endmodule

// File: rtl/acq_seq_rise.sv
`timescale 1ns/1ps
module acq_seq_rise #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], pin};
        end
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/acq_sequencer.sv
`timescale 1ns/1ps
module acq_sequencer
    import acq_seq_pkg::*;
#(
    parameter int CAL_CYCLES  = 256,
    parameter int CONV_CYCLES = 43,
    parameter int WAKE_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr_i,
    input  logic [2:0] cmd_i,
    input  logic [1:0] acq_sel_i,
    input  logic       ext_sync_i,
    input  logic       rd_done_i,
    input  logic       sync_pin_i,
    output logic       sync_pin_o,
    output logic       sync_pin_oe,
    output logic       rdy_n_o,
    output logic       stdby_n_o
);

    localparam int AZ_CYCLES = CAL_CYCLES / 8;
    localparam int TW = $clog2(CAL_CYCLES + WAKE_CYCLES + CONV_CYCLES + 80);

    seq_state_e state_q, state_d;
    logic [2:0] op_q, op_d;

    logic sync_rise_raw, sync_rise;
    logic abort;
    logic wake_done, eng_done, acq_done, conv_done;
    logic wake_go, eng_go, acq_go, conv_go;
    logic [TW-1:0] eng_len, acq_len;
    logic converting;

    // synchronised sync-pin edge, meaningful only when the pin is an input
    acq_seq_rise #(.STAGES(SYNC_STAGES)) i_rise (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (sync_pin_i),
        .rise (sync_rise_raw)
    );
    assign sync_rise = sync_rise_raw & ext_sync_i;

    assign abort = cfg_wr_i && (cmd_i == OP_ABORT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_SLEEP;
            op_q    <= OP_SLEEP;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        if (abort) begin
            state_d = S_READY;
            op_d    = OP_ABORT;
        end else begin
            unique case (state_q)
                S_SLEEP: begin
                    if (cfg_wr_i && cmd_i != OP_SLEEP) begin
                        state_d = S_WAKE;
                        op_d    = cmd_i;
                    end
                end
                S_WAKE: begin
                    if (wake_done) begin
                        if (op_q == OP_FULLCAL)   state_d = S_FULLCAL;
                        else if (op_q == OP_ZERO) state_d = S_ZERO;
                        else                      state_d = S_READY;
                    end
                end
                S_READY: begin
                    if (cfg_wr_i) begin
                        op_d = cmd_i;
                        if (cmd_i == OP_SLEEP)        state_d = S_SLEEP;
                        else if (cmd_i == OP_FULLCAL) state_d = S_FULLCAL;
                        else if (cmd_i == OP_ZERO)    state_d = S_ZERO;
                    end else if (op_q == OP_START) begin
                        if (ext_sync_i) begin
                            if (sync_rise)      state_d = S_CONVERT;
                            else if (rd_done_i) state_d = S_ACQ_EXT;
                        end else if (rd_done_i) begin
                            state_d = S_ACQ_TIMED;
                        end
                    end
                end
                S_ACQ_TIMED: if (acq_done)  state_d = S_CONVERT;
                S_ACQ_EXT:   if (sync_rise) state_d = S_CONVERT;
                S_FULLCAL:   if (eng_done)  state_d = S_READY;
                S_ZERO:      if (eng_done)  state_d = S_READY;
                S_CONVERT:   if (conv_done) state_d = S_READY;
                default:     state_d = S_SLEEP;
            endcase
        end
    end

    // engine and timer launches on state entry
    assign wake_go = (state_d == S_WAKE) && (state_q != S_WAKE);
    assign acq_go  = (state_d == S_ACQ_TIMED) && (state_q != S_ACQ_TIMED);
    assign conv_go = (state_d == S_CONVERT) && (state_q != S_CONVERT);
    assign eng_go  = ((state_d == S_FULLCAL) && (state_q != S_FULLCAL)) ||
                     ((state_d == S_ZERO) && (state_q != S_ZERO));
    assign eng_len = (state_d == S_FULLCAL) ? TW'(CAL_CYCLES) : TW'(AZ_CYCLES);
    assign acq_len = TW'(acq_clocks(acq_sel_i));

    acq_seq_timer #(.W(TW)) i_wake (
        .clk(clk), .rst_n(rst_n), .start(wake_go), .abort(abort),
        .len(TW'(WAKE_CYCLES)), .done(wake_done)
    );

    acq_seq_timer #(.W(TW)) i_acq (
        .clk(clk), .rst_n(rst_n), .start(acq_go), .abort(abort),
        .len(acq_len), .done(acq_done)
    );

    // calibration / auto-zero engine stub
    acq_seq_timer #(.W(TW)) i_cal_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_go), .abort(abort),
        .len(eng_len), .done(eng_done)
    );

    // conversion engine stub
    acq_seq_timer #(.W(TW)) i_conv_eng (
        .clk(clk), .rst_n(rst_n), .start(conv_go), .abort(abort),
        .len(TW'(CONV_CYCLES)), .done(conv_done)
    );

    // outputs
    always_comb begin
        rdy_n_o    = 1'b1;
        stdby_n_o  = 1'b1;
        converting = 1'b0;
        unique case (state_q)
            S_SLEEP:   stdby_n_o  = 1'b0;
            S_READY:   rdy_n_o    = 1'b0;
            S_CONVERT: converting = 1'b1;
            default:   ;
        endcase
        sync_pin_oe = ~ext_sync_i;
        sync_pin_o  = converting & ~ext_sync_i;
    end

endmodule

// File: rtl/acq_sequencer_chk.sv
`timescale 1ns/1ps
module acq_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr_i,
    input logic [2:0] cmd_i,
    input logic       ext_sync_i,
    input logic       sync_pin_o,
    input logic       sync_pin_oe,
    input logic       rdy_n_o,
    input logic       stdby_n_o
);

    // R1
    sleep_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stdby_n_o |-> rdy_n_o);

    // R9
    abort_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && cmd_i == 3'b011) |=> (!rdy_n_o && stdby_n_o));

    // R8
    cal_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n_o && cfg_wr_i && cmd_i == 3'b001) |=> rdy_n_o);

    // R11
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n_o && cfg_wr_i && cmd_i == 3'b000) |=> !stdby_n_o);

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_n_o && stdby_n_o && cfg_wr_i && cmd_i != 3'b011) |=> stdby_n_o);

    // R5
    sync_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pin_o |-> (rdy_n_o && sync_pin_oe));

    // R5
    conv_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sync_pin_o) && $stable(ext_sync_i)) |-> !rdy_n_o);

endmodule

bind acq_sequencer acq_sequencer_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_i   (cfg_wr_i),
    .cmd_i      (cmd_i),
    .ext_sync_i (ext_sync_i),
    .sync_pin_o (sync_pin_o),
    .sync_pin_oe(sync_pin_oe),
    .rdy_n_o    (rdy_n_o),
    .stdby_n_o  (stdby_n_o)
);

// File: tb/test_acq_sequencer.sv
`timescale 1ns/1ps
module test_acq_sequencer;

    localparam int CAL  = 64;
    localparam int CONV = 43;
    localparam int WAKE = 16;
    localparam int AZ   = CAL / 8;

    localparam int M_SLEEP = 0, M_WAKE = 1, M_IDLE = 2, M_CAL = 3,
                   M_AZ = 4, M_ACQ = 5, M_WAITSYNC = 6, M_CONV = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] cmd = 3'b000;
    logic [1:0] sel = 2'b00;
    logic       ext = 1'b0;
    logic       rd = 1'b0;
    logic       pin = 1'b0;
    logic       so, oe, rdy_n, stdby_n;

    always #4 clk = ~clk;

    acq_sequencer #(
        .CAL_CYCLES(CAL), .CONV_CYCLES(CONV), .WAKE_CYCLES(WAKE), .SYNC_STAGES(2)
    ) i_acq_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(wr), .cmd_i(cmd), .acq_sel_i(sel),
        .ext_sync_i(ext), .rd_done_i(rd), .sync_pin_i(pin),
        .sync_pin_o(so), .sync_pin_oe(oe), .rdy_n_o(rdy_n), .stdby_n_o(stdby_n)
    );

    int    m_mode = M_SLEEP;
    int    m_left = 0;
    int    m_op = 0;
    bit    pin_hist[$] = '{1'b0, 1'b0, 1'b0};
    string tag = "R1";
    int    compared = 0;
    int    mismatched = 0;
    int    cycles = 0;
    bit    done_flag = 1'b0;

    function automatic int win_len(input int s);
        if (s == 0) return 9;
        if (s == 1) return 15;
        if (s == 2) return 47;
        return 79;
    endfunction

    // behavioural reference model, advanced on each rising edge
    always @(posedge clk) begin
        bit rise;
        if (!rst_n) begin
            m_mode = M_SLEEP; m_op = 0; m_left = 0;
            pin_hist = '{1'b0, 1'b0, 1'b0};
        end else begin
            rise = ext && pin_hist[1] && !pin_hist[2];
            if (wr && cmd == 3'd3) begin
                m_mode = M_IDLE; m_op = 3;
            end else begin
                case (m_mode)
                    M_SLEEP: if (wr && cmd != 3'd0) begin
                        m_op = int'(cmd); m_mode = M_WAKE; m_left = WAKE;
                    end
                    M_WAKE: begin
                        m_left--;
                        if (m_left == 0) begin
                            if (m_op == 1)      begin m_mode = M_CAL; m_left = CAL; end
                            else if (m_op == 2) begin m_mode = M_AZ;  m_left = AZ;  end
                            else m_mode = M_IDLE;
                        end
                    end
                    M_IDLE: begin
                        if (wr) begin
                            m_op = int'(cmd);
                            if (cmd == 3'd0)      m_mode = M_SLEEP;
                            else if (cmd == 3'd1) begin m_mode = M_CAL; m_left = CAL; end
                            else if (cmd == 3'd2) begin m_mode = M_AZ;  m_left = AZ;  end
                        end else if (m_op == 4) begin
                            if (ext) begin
                                if (rise)    begin m_mode = M_CONV; m_left = CONV; end
                                else if (rd) m_mode = M_WAITSYNC;
                            end else if (rd) begin
                                m_mode = M_ACQ; m_left = win_len(int'(sel));
                            end
                        end
                    end
                    M_ACQ: begin
                        m_left--;
                        if (m_left == 0) begin m_mode = M_CONV; m_left = CONV; end
                    end
                    M_WAITSYNC: if (rise) begin m_mode = M_CONV; m_left = CONV; end
                    default: begin
                        m_left--;
                        if (m_left == 0) m_mode = M_IDLE;
                    end
                endcase
            end
            pin_hist.push_front(pin);
            void'(pin_hist.pop_back());
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // compare every cycle, away from the edge
    always @(posedge clk) begin
        logic [3:0] got, exp;
        #2;
        cycles++;
        got = {rdy_n, stdby_n, so, oe};
        exp = {m_mode != M_IDLE, m_mode != M_SLEEP, (m_mode == M_CONV) && !ext, !ext};
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: {rdy_n,stdby_n,sync_o,sync_oe} actual %b expected %b at %0t",
                     tag, got, exp, $time);
        end
        if (cycles > 100000 && !done_flag) begin
            done_flag = 1'b1;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_op(input logic [2:0] op);
        @(negedge clk); wr = 1'b1; cmd = op;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic read_done();
        @(negedge clk); rd = 1'b1;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic sync_pulse(input int hi);
        @(negedge clk); pin = 1'b1;
        cyc(hi);
        pin = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && m_mode != M_IDLE; i++) @(negedge clk);
        cyc(2);
    endtask

    initial begin
        tag = "R1"; cyc(5); rst_n = 1'b1; cyc(5);
        tag = "R2"; write_op(3'd4); cyc(25);
        for (int s = 0; s < 4; s++) begin
            tag = "R4"; sel = 2'(s);
            read_done(); wait_idle();
        end
        tag = "R5"; sel = 2'd1; read_done(); wait_idle();
        tag = "R12"; write_op(3'd5); read_done(); cyc(12); write_op(3'd4);
        tag = "R8"; write_op(3'd1); wait_idle(); write_op(3'd2); wait_idle();
        tag = "R12"; read_done(); cyc(5);
        tag = "R10"; write_op(3'd4); read_done(); cyc(5); write_op(3'd0); cyc(5);
        write_op(3'd1); wait_idle(); read_done(); wait_idle();
        tag = "R9"; read_done(); cyc(30); write_op(3'd3); cyc(5);
        write_op(3'd1); cyc(20); write_op(3'd3); cyc(3); write_op(3'd4);
        tag = "R3"; ext = 1'b1; cyc(3);
        tag = "R6"; sel = 2'd3; read_done(); cyc(120); sync_pulse(4); wait_idle();
        read_done(); cyc(10); sync_pulse(3); cyc(10); sync_pulse(3); wait_idle(); cyc(10);
        tag = "R7"; sync_pulse(3); wait_idle();
        tag = "R3"; ext = 1'b0; cyc(3);
        tag = "R11"; write_op(3'd0); cyc(5);
        tag = "R9"; write_op(3'd3); cyc(3);
        tag = "R11"; write_op(3'd0); cyc(3);
        tag = "R2"; write_op(3'd2); wait_idle();
        write_op(3'd0); cyc(3); write_op(3'd1); wait_idle(); cyc(5);
        done_flag = 1'b1;
        finish_run();
    end

endmodule